// File: doc/BRIEF.md
# Little-endian byte-lane load/store stage

This block is the data-memory stage of a simple integer core. Each cycle it takes an operation code, a 64-bit base register value, a 12-bit signed offset, a 64-bit store source and a 64-bit pass-through value. It forms the effective address and then does one of three things: it writes one, four or eight bytes to a byte-wide internal memory, it reads them back, or it lets a non-memory result flow on unchanged.

Every wide access is split into separate byte lanes. Lane k addresses the byte at the effective address plus k, so the least significant byte always sits at the lowest address. Narrow loads are sign-extended to 64 bits. The memory is a small array meant for testing. Its index is the low address bits, so higher addresses alias onto it. A synchronous active-low reset clears it to zero. A load result is combinational from the current memory contents. A store is committed at the rising clock edge, so it is visible to a load in the following cycle.

Top module: `lsu_mem_stage`

## Requirements
- R1: Each memory location holds one byte. The memory has 2^ADDR_BITS locations, and a byte address selects location (address mod 2^ADDR_BITS). Two addresses that differ by a multiple of 2^ADDR_BITS therefore reach the same byte, and so do the lanes of an access that crosses the top of the array.
- R2: Byte order is little-endian. An 8-byte store to address a puts bits 7:0 at a and bits 63:56 at a+7. A byte load from a+k returns source bits 8k+7:8k.
- R3: A location not written since the last reset reads as zero. Holding rst_n low for one or more rising edges clears the whole memory.
- R4: Loads of one, four and eight bytes read that many consecutive bytes. Stores of one, four and eight bytes write only the low 1, 4 or 8 bytes of store_data_i and leave every other location unchanged.
- R5: A 1-byte load sign-extends from bit 7 and a 4-byte load sign-extends from bit 31 to 64 bits. An 8-byte load returns the bytes unchanged.
- R6: The effective address is base_i plus offset_i sign-extended to 64 bits, taken modulo 2^64.
- R7: A store followed in the next cycle by a load of the same width and effective address returns the stored value, sign-extended as in R5.
- R8: For non-memory operations result_o equals pass_data_i in the same cycle and memory is not changed. During a store result_o is zero.
- R9: op_i encoding: 3'b000 none, 3'b001 load byte, 3'b010 load word (4 bytes), 3'b011 load doubleword (8 bytes), 3'b101 store byte, 3'b110 store word, 3'b111 store doubleword. 3'b100 behaves as none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears memory |
| op_i | input | 3 | Operation code (see R9) |
| base_i | input | 64 | Base address register value |
| offset_i | input | 12 | Signed address offset |
| store_data_i | input | 64 | Store source register value |
| pass_data_i | input | 64 | Result of a non-memory instruction |
| result_o | output | 64 | Load result, pass-through value, or zero on stores |

## Verification
The bench builds the block with ADDR_BITS set to 5, which gives a 32-byte array. With so few locations, random addresses drawn from the full 64-bit space collide often, so stores are frequently overwritten, partly overwritten by narrower stores, and read back at other widths. The small array also means doubleword accesses often straddle the top of the array and wrap into its low bytes. Bases near 2^64 paired with positive offsets reach the modulo-2^64 wrap of the effective address.

// File: rtl/lsu_pkg.sv
// Shared definitions for the load/store stage.
// Assumes a 3-bit operation code. Bit 2 marks a store, and bits 1:0 give the size
// code: 1 = byte, 2 = word, 3 = doubleword.
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'b000,
        OP_LB   = 3'b001,
        OP_LW   = 3'b010,
        OP_LD   = 3'b011,
        OP_RSVD = 3'b100,
        OP_SB   = 3'b101,
        OP_SW   = 3'b110,
        OP_SD   = 3'b111
    } lsu_op_e;

    // Number of bytes that a size code covers.
    function automatic int unsigned lane_count(input logic [1:0] size_code);
        case (size_code)
            2'd1:    return 1;
            2'd2:    return 4;
            2'd3:    return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective address adder.
// Adds a sign-extended offset to the base register. The sum wraps modulo 2^ADDR_W.
module lsu_addr_gen #(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - OFS_W;

    // Sign-extend the offset and add it to the base.
    always_comb begin
        ea_o = base_i + {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
    end
endmodule

// File: rtl/lsu_byte_mem.sv
// Byte-wide data array with one read and one write port per byte lane.
// Lane k addresses base_idx + k, wrapping inside the array.
// Assumes LANES <= 2^IDX_W, so no two lanes of one access reach the same byte.
// Reads are combinational. Writes and the reset clear happen on the rising edge.
module lsu_byte_mem #(
    parameter int IDX_W = 6,
    parameter int LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     base_idx_i,
    input  logic [LANES-1:0]     wr_en_i,
    input  logic [LANES*8-1:0]   wr_data_i,
    output logic [LANES*8-1:0]   rd_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] lane_idx [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Byte address of this lane, wrapping inside the array.
        assign lane_idx[k] = base_idx_i + IDX_W'(k);
        // Combinational read of this lane's byte.
        assign rd_data_o[8*k +: 8] = mem[lane_idx[k]];
    end

    // Clear on reset, otherwise commit the enabled lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_en_i[k]) mem[lane_idx[k]] <= wr_data_i[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/lsu_load_align.sv
// Load result formatter.
// Keeps the low 1, 4 or 8 bytes of the raw lane data and sign-extends narrow sizes.
// Assumes DATA_W is 64.
module lsu_load_align #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [1:0]        size_i,
    output logic [DATA_W-1:0] value_o
);
    localparam int B_EXT = DATA_W - 8;
    localparam int W_EXT = DATA_W - 32;

    // Select the width and extend its top bit.
    always_comb begin
        case (size_i)
            2'd1:    value_o = {{B_EXT{raw_i[7]}},  raw_i[7:0]};
            2'd2:    value_o = {{W_EXT{raw_i[31]}}, raw_i[31:0]};
            2'd3:    value_o = raw_i;
            default: value_o = '0;
        endcase
    end
endmodule

// File: rtl/lsu_mem_stage.sv
// Memory stage of the core.
// Forms the effective address, splits the access into little-endian byte lanes,
// writes stores at the clock edge and returns loads combinationally.
// Non-memory operations pass their value through unchanged.
// Assumes ADDR_BITS >= 3 so that one doubleword never overlaps itself.
module lsu_mem_stage #(
    parameter int ADDR_BITS   = 6,
    parameter int OFFSET_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic [63:0] base_i,
    input  logic [OFFSET_BITS-1:0] offset_i,
    input  logic [63:0] store_data_i,
    input  logic [63:0] pass_data_i,
    output logic [63:0] result_o
);
    import lsu_pkg::*;

    localparam int XLEN  = 64;
    localparam int LANES = XLEN / 8;

    logic [XLEN-1:0]  ea;
    logic [LANES-1:0] lane_en;
    logic [XLEN-1:0]  raw_rd;
    logic [XLEN-1:0]  load_val;
    logic [1:0]       size_code;
    logic             is_store;
    logic             is_load;

    assign size_code = op_i[1:0];
    assign is_store  = op_i[2] && (size_code != 2'd0);
    assign is_load   = !op_i[2] && (size_code != 2'd0);

    lsu_addr_gen #(.ADDR_W(XLEN), .OFS_W(OFFSET_BITS)) u_agen (
        .base_i (base_i),
        .ofs_i  (offset_i),
        .ea_o   (ea)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_en
        // Enable a lane when a store covers it.
        assign lane_en[k] = is_store && (k < lane_count(size_code));
    end

    lsu_byte_mem #(.IDX_W(ADDR_BITS), .LANES(LANES)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_idx_i (ea[ADDR_BITS-1:0]),
        .wr_en_i    (lane_en),
        .wr_data_i  (store_data_i),
        .rd_data_o  (raw_rd)
    );

    lsu_load_align #(.DATA_W(XLEN)) u_align (
        .raw_i   (raw_rd),
        .size_i  (size_code),
        .value_o (load_val)
    );

    // Choose between the load value, zero for stores, and the pass-through value.
    always_comb begin
        if (is_load)       result_o = load_val;
        else if (is_store) result_o = '0;
        else               result_o = pass_data_i;
    end
endmodule

// File: rtl/lsu_mem_stage_chk.sv
// Property checker for the memory stage, bound to every instance.
module lsu_mem_stage_chk #(
    parameter int OFFSET_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic [63:0] base_i,
    input logic [OFFSET_BITS-1:0] offset_i,
    input logic [63:0] store_data_i,
    input logic [63:0] pass_data_i,
    input logic [63:0] result_o
);
    logic [63:0] chk_ea;
    logic        past_ok;

    assign chk_ea = base_i + {{(64-OFFSET_BITS){offset_i[OFFSET_BITS-1]}}, offset_i};

    // Mark that at least one cycle has passed out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b000 || op_i == 3'b100) |-> result_o == pass_data_i); // R8
    AST_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2] && op_i[1:0] != 2'b00) |-> result_o == 64'd0); // R8
    AST_BYTE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b001) |-> result_o[63:8] == {56{result_o[7]}}); // R5
    AST_WORD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b010) |-> result_o[63:32] == {32{result_o[31]}}); // R5
    AST_DWORD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 3'b111 && op_i == 3'b011 && chk_ea == $past(chk_ea))
        |-> result_o == $past(store_data_i)); // R7
endmodule

bind lsu_mem_stage lsu_mem_stage_chk #(.OFFSET_BITS(OFFSET_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .base_i       (base_i),
    .offset_i     (offset_i),
    .store_data_i (store_data_i),
    .pass_data_i  (pass_data_i),
    .result_o     (result_o)
);

// File: tb/lsu_mem_stage_tb.sv
// Self-checking bench: directed corner cases, then seeded random operations,
// all compared against a byte-array reference model.
module lsu_mem_stage_tb;
    localparam int AB = 5;
    localparam int MB = 1 << AB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [63:0] base = '0;
    logic [11:0] ofs = '0;
    logic [63:0] sdata = '0;
    logic [63:0] pdata = '0;
    logic [63:0] result;

    logic [7:0] model [MB];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lsu_mem_stage #(.ADDR_BITS(AB), .OFFSET_BITS(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .base_i(base), .offset_i(ofs),
        .store_data_i(sdata), .pass_data_i(pdata), .result_o(result)
    );

    function automatic logic [63:0] ea_of(input logic [63:0] b, input logic [11:0] o);
        return b + {{52{o[11]}}, o};
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd1) ? 1 : (sz == 2'd2) ? 4 : (sz == 2'd3) ? 8 : 0;
    endfunction

    function automatic logic [63:0] expect_val(input logic [2:0] o, input logic [63:0] ea,
                                               input logic [63:0] pd);
        logic [63:0] v;
        int n;
        n = nbytes(o[1:0]);
        if (n == 0) return pd;
        if (o[2]) return 64'd0;
        v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = model[AB'(ea + 64'(k))];
        if (n == 1) v = {{56{v[7]}}, v[7:0]};
        if (n == 4) v = {{32{v[31]}}, v[31:0]};
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input logic [2:0] o, input logic [63:0] b, input logic [11:0] f,
                        input logic [63:0] sd, input logic [63:0] pd, input string req);
        logic [63:0] ea;
        @(negedge clk);
        op = o; base = b; ofs = f; sdata = sd; pdata = pd;
        #1;
        ea = ea_of(b, f);
        check(req, result, expect_val(o, ea, pd));
        if (o[2] && nbytes(o[1:0]) != 0)
            for (int k = 0; k < nbytes(o[1:0]); k++) model[AB'(ea + 64'(k))] = sd[8*k +: 8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op = 3'b000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < MB; i++) model[i] = 8'h00;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] ops [11];
        void'($urandom(32'd20240611));
        ops = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111,
                3'b011, 3'b111, 3'b001};
        do_reset();
        // R3: memory reads zero after reset
        step(3'b011, 64'd0, 12'd0, '0, '0, "R3 reset zero low");
        step(3'b011, 64'd24, 12'd0, '0, '0, "R3 reset zero high");
        // R2: little-endian lane placement
        step(3'b111, 64'd8, 12'd0, 64'h8877_6655_4433_2211, '0, "R2 store");
        for (int k = 0; k < 8; k++)
            step(3'b001, 64'd8 + 64'(k), 12'd0, '0, '0, "R2 byte lane");
        // R4: byte store leaves neighbours intact, word store width
        step(3'b101, 64'd9, 12'd0, 64'hFFFF_FFFF_FFFF_FFAA, '0, "R4 byte store");
        step(3'b011, 64'd8, 12'd0, '0, '0, "R4 neighbours kept");
        step(3'b110, 64'd16, 12'd0, 64'h1234_5678_0BAD_F00D, '0, "R4 word store");
        step(3'b011, 64'd16, 12'd0, '0, '0, "R4 word width");
        // R5: sign extension
        step(3'b101, 64'd2, 12'd0, 64'h80, '0, "R5 store");
        step(3'b001, 64'd2, 12'd0, '0, '0, "R5 byte negative");
        step(3'b110, 64'd4, 12'd0, 64'h8000_0001, '0, "R5 store");
        step(3'b010, 64'd4, 12'd0, '0, '0, "R5 word negative");
        step(3'b110, 64'd4, 12'd0, 64'h7FFF_FFFF, '0, "R5 store");
        step(3'b010, 64'd4, 12'd0, '0, '0, "R5 word positive");
        // R6: negative offset and 2^64 wrap
        step(3'b111, 64'h10, 12'hFF8, 64'hCAFE_BABE_DEAD_BEEF, '0, "R6 store neg ofs");
        step(3'b011, 64'h8, 12'd0, '0, '0, "R6 neg ofs");
        step(3'b111, 64'hFFFF_FFFF_FFFF_FFFC, 12'd8, 64'h0102_0304_0506_0708, '0, "R6 store wrap");
        step(3'b011, 64'd4, 12'd0, '0, '0, "R6 wrap 2^64");
        // R1: aliasing and lane wrap at array top
        step(3'b011, 64'd4 + 64'(MB), 12'd0, '0, '0, "R1 alias");
        step(3'b111, 64'(MB - 3), 12'd0, 64'hA1A2_A3A4_A5A6_A7A8, '0, "R1 store top");
        step(3'b010, 64'd0, 12'd0, '0, '0, "R1 lane wrap");
        // R7: store then load next cycle
        step(3'b110, 64'd20, 12'd0, 64'hFEDC_BA98, '0, "R7 store");
        step(3'b010, 64'd20, 12'd0, '0, '0, "R7 load back");
        // R8, R9: pass-through codes
        step(3'b000, 64'd0, 12'd0, 64'hFFFF, 64'h1357_9BDF_2468_ACE0, "R8 none");
        step(3'b100, 64'd0, 12'd0, 64'hFFFF, 64'h0F0F_0F0F_0F0F_0F0F, "R9 reserved");
        step(3'b011, 64'd0, 12'd0, '0, '0, "R8 no write");
        // Random mix over the whole address space
        for (int i = 0; i < 600; i++) begin
            logic [63:0] b;
            b = ($urandom % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 64);
            step(ops[$urandom % 11], b, 12'($urandom), {$urandom, $urandom},
                 {$urandom, $urandom}, "R4 R7 random");
        end
        // R3: a second reset clears written data
        do_reset();
        for (int a = 0; a < MB; a += 8)
            step(3'b011, 64'(a), 12'd0, '0, '0, "R3 cleared");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule